// File: doc/BRIEF.md
# Serially Programmed Reference Divider

This block is the programming front end and reference divider of a frequency synthesizer. A 19-bit word enters one bit at a time, most significant bit first, on a shift strobe. On the rising edge of a latch enable, the word is routed by its final bit. That bit is the control bit, and it picks one of two destinations. The first destination is a 14-bit reference divide ratio together with a 1-bit prescaler mode select. The second is an 18-bit main-divider word.

The latched ratio drives a programmable reference counter. This counter divides the block clock and emits a one-clock pulse once per ratio. The main-divider word and the prescaler mode bit are presented as register outputs for the divider stages that follow. All logic runs on one clock. The serial clock edge and the latch enable reach the block as a synchronous strobe and a level.

Top module: `synth_ref_divider`

## Requirements
- R1: On each clock with `shift_stb` high, `sdata` enters bit 0 of the 19-bit shift word and all older bits move one place up, so the first bit sent ends in bit 18. While `shift_stb` is low, `sdata` has no effect.
- R2: A load with control bit (word bit 0) equal to 1 sets `ref_ratio` to word bits 14..1 (bit 14 most significant) and `presc_sel` to word bit 15. It leaves `main_word` unchanged, and word bits 18..16 are ignored. `presc_sel` = 1 selects the 64/65 prescaler mode and 0 selects 128/129.
- R3: A load with control bit equal to 0 sets `main_word` to word bits 18..1 and leaves `ref_ratio` and `presc_sel` unchanged.
- R4: A load happens only on a low-to-high change of `latch_en`, and the new latch values appear one clock after the clock that first sees `latch_en` high. Holding `latch_en` high does not load again.
- R5: `ref_pulse` is high for exactly one clock per period, and the period equals `ref_ratio` clocks for ratios 3 to 16383.
- R6: A ratio of 0, 1 or 2 is divided as 3.
- R7: A newly loaded ratio is adopted only at the next terminal count, so the period in progress when the load occurs keeps its old length.
- R8: Synchronous reset clears `ref_ratio`, `presc_sel` and `main_word` to 0, which gives an effective ratio of 3. The first `ref_pulse` after reset release appears on the third clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, also the reference clock being divided |
| rst | input | 1 | Synchronous active-high reset |
| sdata | input | 1 | Serial data bit |
| shift_stb | input | 1 | Shift strobe: sample `sdata` on this clock |
| latch_en | input | 1 | Latch enable; rising edge transfers the word |
| ref_ratio | output | 14 | Latched reference divide ratio |
| presc_sel | output | 1 | Prescaler mode: 1 = 64/65, 0 = 128/129 |
| main_word | output | 18 | Latched main-divider word |
| ref_pulse | output | 1 | One-clock pulse per reference period |

## Verification
The bench builds the block with its default widths: a 19-bit word, a 14-bit ratio and an 18-bit main word, with a minimum ratio of 3. With these widths the largest ratio, 16383, can be measured in full within the run. The bench also loads a ratio in the middle of that long period, which exercises the terminal-count pickup. Ratios 0 and 1 exercise the clamp, and ratios 3 and 4 sit at the low edge of the legal range.

// File: rtl/sref_pkg.sv
package sref_pkg;
    localparam int DEF_WORD_W  = 19;
    localparam int DEF_RATIO_W = 14;
    localparam int DEF_MAIN_W  = 18;
    localparam int DEF_MIN_RAT = 3;

    typedef enum logic {
        DEST_MAIN = 1'b0,
        DEST_REF  = 1'b1
    } dest_e;
endpackage

// File: rtl/sref_shift.sv
module sref_shift #(
    parameter int WORD_W = sref_pkg::DEF_WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              shift_stb,
    input  logic              sdata,
    output logic [WORD_W-1:0] word
);
    typedef struct packed {
        logic [WORD_W-1:0] sr;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (shift_stb) begin
            st_d.sr = {st_q.sr[WORD_W-2:0], sdata};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word = st_q.sr;
endmodule

// File: rtl/sref_route.sv
module sref_route
    import sref_pkg::*;
#(
    parameter int WORD_W  = DEF_WORD_W,
    parameter int RATIO_W = DEF_RATIO_W,
    parameter int MAIN_W  = DEF_MAIN_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               latch_en,
    input  logic [WORD_W-1:0]  word,
    output logic               load,
    output logic [RATIO_W-1:0] ratio,
    output logic               presc,
    output logic [MAIN_W-1:0]  main
);
    localparam int PS_BIT = RATIO_W + 1;

    typedef struct packed {
        logic               le;
        logic [RATIO_W-1:0] ratio;
        logic               presc;
        logic [MAIN_W-1:0]  main;
    } state_t;

    state_t st_d, st_q;
    dest_e  dest;

    assign dest = dest_e'(word[0]);
    assign load = latch_en && !st_q.le;

    always_comb begin
        st_d    = st_q;
        st_d.le = latch_en;
        if (load) begin
            case (dest)
                DEST_REF: begin
                    st_d.ratio = word[RATIO_W:1];
                    st_d.presc = word[PS_BIT];
                end
                default: begin
                    st_d.main = word[MAIN_W:1];
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ratio = st_q.ratio;
    assign presc = st_q.presc;
    assign main  = st_q.main;
endmodule

// File: rtl/sref_refcnt.sv
module sref_refcnt #(
    parameter int RATIO_W = sref_pkg::DEF_RATIO_W,
    parameter int MIN_RAT = sref_pkg::DEF_MIN_RAT
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [RATIO_W-1:0] ratio,
    output logic               pulse
);
    localparam logic [RATIO_W-1:0] MIN_V   = RATIO_W'(MIN_RAT);
    localparam logic [RATIO_W-1:0] START_V = RATIO_W'(MIN_RAT - 1);

    typedef struct packed {
        logic [RATIO_W-1:0] cnt;
        logic               pulse;
    } state_t;

    state_t             st_d, st_q;
    logic [RATIO_W-1:0] eff;

    assign eff = (ratio < MIN_V) ? MIN_V : ratio;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == '0) begin
            st_d.cnt   = eff - 1'b1;
            st_d.pulse = 1'b1;
        end else begin
            st_d.cnt   = st_q.cnt - 1'b1;
            st_d.pulse = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.cnt   <= START_V;
            st_q.pulse <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pulse = st_q.pulse;
endmodule

// File: rtl/synth_ref_divider.sv
module synth_ref_divider #(
    parameter int WORD_W  = sref_pkg::DEF_WORD_W,
    parameter int RATIO_W = sref_pkg::DEF_RATIO_W,
    parameter int MAIN_W  = sref_pkg::DEF_MAIN_W,
    parameter int MIN_RAT = sref_pkg::DEF_MIN_RAT
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sdata,
    input  logic               shift_stb,
    input  logic               latch_en,
    output logic [RATIO_W-1:0] ref_ratio,
    output logic               presc_sel,
    output logic [MAIN_W-1:0]  main_word,
    output logic               ref_pulse
);
    logic [WORD_W-1:0] shift_word;
    logic              load_pulse;

    sref_shift #(.WORD_W(WORD_W)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .shift_stb (shift_stb),
        .sdata     (sdata),
        .word      (shift_word)
    );

    sref_route #(.WORD_W(WORD_W), .RATIO_W(RATIO_W), .MAIN_W(MAIN_W)) u_route (
        .clk      (clk),
        .rst      (rst),
        .latch_en (latch_en),
        .word     (shift_word),
        .load     (load_pulse),
        .ratio    (ref_ratio),
        .presc    (presc_sel),
        .main     (main_word)
    );

    sref_refcnt #(.RATIO_W(RATIO_W), .MIN_RAT(MIN_RAT)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .ratio (ref_ratio),
        .pulse (ref_pulse)
    );
endmodule

// File: rtl/sref_checker.sv
module sref_checker #(
    parameter int WORD_W  = 19,
    parameter int RATIO_W = 14,
    parameter int MAIN_W  = 18
) (
    input logic               clk,
    input logic               rst,
    input logic               sdata,
    input logic               shift_stb,
    input logic               latch_en,
    input logic [WORD_W-1:0]  shift_word,
    input logic [RATIO_W-1:0] ref_ratio,
    input logic               presc_sel,
    input logic [MAIN_W-1:0]  main_word,
    input logic               ref_pulse
);
    logic le_prev;

    always_ff @(posedge clk) begin
        if (rst) le_prev <= 1'b0;
        else     le_prev <= latch_en;
    end

    AST_SHIFT_IN: assert property (@(posedge clk) disable iff (rst)
        shift_stb |=> shift_word[0] == $past(sdata)); // R1

    AST_ROUTE_REF: assert property (@(posedge clk) disable iff (rst)
        (latch_en && !le_prev && shift_word[0]) |=>
            (ref_ratio == $past(shift_word[RATIO_W:1]) &&
             presc_sel == $past(shift_word[RATIO_W+1]) && $stable(main_word))); // R2

    AST_ROUTE_MAIN: assert property (@(posedge clk) disable iff (rst)
        (latch_en && !le_prev && !shift_word[0]) |=>
            (main_word == $past(shift_word[MAIN_W:1]) &&
             $stable(ref_ratio) && $stable(presc_sel))); // R3

    AST_NO_RELOAD: assert property (@(posedge clk) disable iff (rst)
        !(latch_en && !le_prev) |=>
            ($stable(ref_ratio) && $stable(presc_sel) && $stable(main_word))); // R4

    AST_PULSE_ONE_WIDE: assert property (@(posedge clk) disable iff (rst)
        ref_pulse |=> !ref_pulse); // R5
endmodule

bind synth_ref_divider sref_checker #(
    .WORD_W(WORD_W), .RATIO_W(RATIO_W), .MAIN_W(MAIN_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .sdata      (sdata),
    .shift_stb  (shift_stb),
    .latch_en   (latch_en),
    .shift_word (shift_word),
    .ref_ratio  (ref_ratio),
    .presc_sel  (presc_sel),
    .main_word  (main_word),
    .ref_pulse  (ref_pulse)
);

// File: tb/sim_synth_ref_divider.sv
module sim_synth_ref_divider;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sdata = 1'b0;
    logic        shift_stb = 1'b0;
    logic        latch_en = 1'b0;
    logic [13:0] ref_ratio;
    logic        presc_sel;
    logic [17:0] main_word;
    logic        ref_pulse;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int pcnt = 0;
    int prev_ts = 0;
    int last_ts = 0;
    bit pulse_seen_prev = 1'b0;
    bit wide_pulse = 1'b0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    synth_ref_divider u0 (
        .clk(clk), .rst(rst), .sdata(sdata), .shift_stb(shift_stb),
        .latch_en(latch_en), .ref_ratio(ref_ratio), .presc_sel(presc_sel),
        .main_word(main_word), .ref_pulse(ref_pulse)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (!rst && ref_pulse) begin
            prev_ts = last_ts;
            last_ts = cyc;
            pcnt    = pcnt + 1;
            if (pulse_seen_prev) wide_pulse = 1'b1;
        end
        pulse_seen_prev = !rst && ref_pulse;
    end

    // word bits: [18:1] payload, [0] control; ref payload [15] presc, [14:1] ratio
    localparam logic [51:0] VEC [6] = '{
        {19'h08009, 14'd4,     1'b1, 18'h00000},
        {19'h54B4A, 14'd4,     1'b1, 18'h2A5A5},
        {19'h57FFF, 14'h3FFF,  1'b0, 18'h2A5A5},
        {19'h00002, 14'h3FFF,  1'b0, 18'h00001},
        {19'h08007, 14'd3,     1'b1, 18'h00001},
        {19'h7FFFE, 14'd3,     1'b1, 18'h3FFFF}
    };

    task automatic check(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    task automatic shift_word(input logic [18:0] w);
        for (int i = 18; i >= 0; i--) begin
            @(negedge clk);
            sdata = w[i];
            shift_stb = 1'b1;
        end
        @(negedge clk);
        shift_stb = 1'b0;
    endtask

    task automatic load_word(input logic [18:0] w);
        shift_word(w);
        latch_en = 1'b1;
        @(negedge clk);
        latch_en = 1'b0;
        @(negedge clk);
    endtask

    function automatic logic [18:0] mk_ref(input logic [13:0] r, input logic ps);
        return {3'b000, ps, r, 1'b1};
    endfunction

    task automatic wait_pulse();
        int s = pcnt;
        while (pcnt == s) @(posedge clk);
    endtask

    task automatic check_period(input string req, input logic [13:0] r, input int exp);
        load_word(mk_ref(r, 1'b1));
        wait_pulse();
        wait_pulse();
        check(req, "period", last_ts - prev_ts, exp);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        int c0;
        repeat (3) @(negedge clk);
        // R8: cleared state during reset
        check("R8", "ratio in reset", ref_ratio, 0);
        check("R8", "presc in reset", presc_sel, 0);
        check("R8", "main in reset", main_word, 0);
        check("R8", "pulse in reset", ref_pulse, 0);
        rst = 1'b0;
        c0 = cyc;
        wait_pulse();
        check("R8", "first pulse delay", last_ts - c0, 3);
        wait_pulse();
        check("R8", "default period", last_ts - prev_ts, 3);

        foreach (VEC[k]) begin
            logic [18:0] w;
            w = VEC[k][51:33];
            load_word(w);
            if (w[0]) begin
                check("R2", "ratio", ref_ratio, int'(VEC[k][32:19]));
                check("R2", "presc", presc_sel, int'(VEC[k][18]));
                check("R2", "main kept", main_word, int'(VEC[k][17:0]));
            end else begin
                check("R3", "main", main_word, int'(VEC[k][17:0]));
                check("R3", "ratio kept", ref_ratio, int'(VEC[k][32:19]));
                check("R3", "presc kept", presc_sel, int'(VEC[k][18]));
            end
        end

        check_period("R5", 14'd4, 4);
        check_period("R5", 14'd3, 3);
        check_period("R6", 14'd1, 3);
        check_period("R6", 14'd0, 3);
        check_period("R5", 14'h3FFF, 16383);

        // R7: load mid-period, current long period must finish unchanged
        load_word(mk_ref(14'd4, 1'b1));
        wait_pulse();
        check("R7", "old period kept", last_ts - prev_ts, 16383);
        wait_pulse();
        check("R7", "new period", last_ts - prev_ts, 4);

        // R4: latch_en held high; R1: sdata without strobe ignored
        shift_word(mk_ref(14'd5, 1'b0));
        latch_en = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R4", "load on rise", ref_ratio, 5);
        shift_word(mk_ref(14'd7, 1'b0));
        repeat (2) @(negedge clk);
        check("R4", "no reload while high", ref_ratio, 5);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            sdata = ~sdata;
        end
        latch_en = 1'b0;
        @(negedge clk);
        latch_en = 1'b1;
        @(negedge clk);
        latch_en = 1'b0;
        @(negedge clk);
        check("R1", "unstrobed data ignored", ref_ratio, 7);
        check("R1", "presc after reload", presc_sel, 0);

        check("R5", "pulse width one clock", int'(wide_pulse), 0);

        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R8", "ratio cleared", ref_ratio, 0);
        check("R8", "main cleared", main_word, 0);
        summary();
    end
endmodule